// File: doc/BRIEF.md
# Serial Peripheral Master with Flow-Controlled Queues

This block is a register-programmed serial peripheral master. Software fills a transmit queue with frames of 8 or 16 bits, sets how many frames the transfer holds, then switches the engine on. The engine shifts each frame out most significant bit first on `mosi_o` and captures `miso_i` into a receive queue. It supports all four clock polarity and phase combinations, and one-hot chip selects that are active low on the pins.

The engine never loses data. Before each frame it checks both queues. A full receive queue holds the serial clock at its idle level. So does an empty transmit queue in full-duplex mode. The engine then waits for software to catch up. In receive-only mode it generates the clocks itself and shifts out zeros, so long read bursts need no transmit traffic. Switching the engine off flushes both queues. The clock divider accepts only even values, and any value that is written is rounded to a legal one.

Top module: `spi_master_ctl`

## Requirements
- R1: Register word addresses: 0 control, 1 frame count, 2 enable, 3 select, 4 divisor, 5 receive level, 6 transmit level, 7 status, 8 data (a write pushes to the transmit queue, a read pops the receive queue). Control bits: bit0 clock idle level, bit1 phase (1 = sample on the second edge), bit2 16-bit frames, bit3 receive-only. Status bits: bit0 busy, bit1 transmit queue full, bit2 receive queue empty. After reset: status reads 4, all `cs_no` are high, `sclk_o` is 0, the divisor reads 2 and both levels read 0.
- R2: The stored divisor is always even and at least 2. Written values 0 and 1 become 2. An odd value becomes the next even value. The all-ones value becomes the largest even value. Within a frame, consecutive `sclk_o` edges are divisor/2 module clocks apart.
- R3: Frames are 8 or 16 bits, sent most significant bit first. In every phase/polarity mode, a looped-back transfer returns each written frame in the receive queue. `sclk_o` rests at the programmed idle level between frames and after a transfer, and each frame makes two edges per bit.
- R4: The frame count holds frames minus one. Exactly count+1 frames are shifted, and busy falls after the final bit of the last frame. This includes the all-ones count.
- R5: Once busy has fallen, data written to the transmit queue is not shifted until enable is written 0 and then 1.
- R6: In full-duplex mode, an empty transmit queue holds the clock at its idle level before the next frame, with busy still high. The transfer resumes when a frame is written.
- R7: A full receive queue holds the clock before the next frame. No received frame is dropped or overwritten, and shifting resumes when software reads.
- R8: In receive-only mode, frames run without transmit data and `mosi_o` stays 0.
- R9: Writing 0 to enable stops the engine at once, flushes both queues, clears busy and returns `sclk_o` to its idle level.
- R10: Writes to the control, frame count and divisor registers are ignored while enable is 1.
- R11: The select register keeps only the lowest set bit of the written value. Each `cs_no` line is the inverse of its select bit, so at most one line is low.
- R12: Each queue holds DEPTH entries, and its level reads 0 to DEPTH. A data write to a full transmit queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the receive queue at the data address) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | NUM_CS | Chip selects, active low |

## Verification
The bench builds the block with DEPTH=4, CNT_W=6 and NUM_CS=4. The shallow queues let a few frames fill the receive queue and exercise the overrun stall. The 6-bit frame counter makes the all-ones count a 64-frame transfer, so the full wrap of the counter can be run to completion. A loopback with optional inversion on the serial input supplies known receive data in every mode, and receive-only bursts return all-ones words.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_COUNT  = 4'd1,
    A_ENABLE = 4'd2,
    A_SELECT = 4'd3,
    A_DIV    = 4'd4,
    A_RXLVL  = 4'd5,
    A_TXLVL  = 4'd6,
    A_STATUS = 4'd7,
    A_DATA   = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic rx_only;
    logic wide;
    logic cpha;
    logic cpol;
  } ctrl_t;

  localparam int FRAME_W = 16;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign rdata_o = mem_q[rptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_inc(wptr_q);
      if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + LW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - LW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q] <= wdata_i;
  end

  assert_level_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));

  // writers must gate their pushes with full
  assert_push_not_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16,
  localparam int HW   = DIV_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             wide_i,
  input  logic             rx_only_i,
  input  logic [HW-1:0]    half_i,
  input  logic [CNT_W-1:0] cnt_max_i,
  input  logic             tx_empty_i,
  input  logic [15:0]      tx_data_i,
  output logic             tx_pop_o,
  input  logic             rx_full_i,
  output logic             rx_push_o,
  output logic [15:0]      rx_data_o,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             busy_o
);

  typedef enum logic {S_IDLE, S_SHIFT} st_e;

  st_e             st_q;
  logic            busy_q, sclk_q, mosi_q;
  logic [HW-1:0]   hcnt_q;
  logic [4:0]      ecnt_q;
  logic [CNT_W-1:0] frm_q;
  logic [15:0]     tx_sh_q, rx_sh_q, ld, rx_next;
  logic            go, tick, last_e, odd, do_smp, do_drv;

  assign go       = (st_q == S_IDLE) && busy_q && !start_i && !stop_i && !rx_full_i
                    && (rx_only_i || !tx_empty_i);
  assign tx_pop_o = go && !rx_only_i;
  assign tick     = (st_q == S_SHIFT) && (hcnt_q == half_i - HW'(1));
  assign last_e   = (ecnt_q == (wide_i ? 5'd31 : 5'd15));
  assign odd      = !ecnt_q[0];
  assign do_smp   = tick && (odd ^ cpha_i);
  assign do_drv   = tick && (cpha_i ? odd : (!odd && !last_e));
  assign rx_next  = {rx_sh_q[14:0], miso_i};
  assign ld       = rx_only_i ? 16'h0 : (wide_i ? tx_data_i : {tx_data_i[7:0], 8'h00});

  assign rx_push_o = tick && last_e && !stop_i;
  always_comb begin
    logic [15:0] src;
    src = cpha_i ? rx_next : rx_sh_q;
    rx_data_o = wide_i ? src : {8'h00, src[7:0]};
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      hcnt_q  <= '0;
      ecnt_q  <= '0;
      frm_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (stop_i) begin
      st_q   <= S_IDLE;
      busy_q <= 1'b0;
      sclk_q <= cpol_i;
      mosi_q <= 1'b0;
    end else if (start_i) begin
      st_q   <= S_IDLE;
      busy_q <= 1'b1;
      frm_q  <= '0;
      sclk_q <= cpol_i;
      mosi_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          sclk_q <= cpol_i;
          if (go) begin
            st_q    <= S_SHIFT;
            hcnt_q  <= '0;
            ecnt_q  <= '0;
            rx_sh_q <= '0;
            if (cpha_i) begin
              tx_sh_q <= ld;
              mosi_q  <= 1'b0;
            end else begin
              tx_sh_q <= {ld[14:0], 1'b0};
              mosi_q  <= ld[15];
            end
          end
        end
        S_SHIFT: begin
          if (tick) begin
            hcnt_q <= '0;
            sclk_q <= ~sclk_q;
            ecnt_q <= ecnt_q + 5'd1;
            if (do_drv) begin
              mosi_q  <= tx_sh_q[15];
              tx_sh_q <= {tx_sh_q[14:0], 1'b0};
            end
            if (do_smp) rx_sh_q <= rx_next;
            if (last_e) begin
              st_q  <= S_IDLE;
              frm_q <= frm_q + CNT_W'(1);
              if (frm_q == cnt_max_i) busy_q <= 1'b0;
            end
          end else begin
            hcnt_q <= hcnt_q + HW'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && $stable(cpol_i) && !$past(stop_i) && !$past(start_i)
     && $past(st_q) == S_IDLE) |-> sclk_q == cpol_i);

  assert_tx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && tx_empty_i && !rx_only_i) |=> st_q == S_IDLE);

  assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && rx_full_i) |=> st_q == S_IDLE);

  assert_rxonly_mosi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_only_i && st_q == S_SHIFT && $past(st_q) == S_SHIFT) |-> !mosi_q);

  assert_busy_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !$past(stop_i)) |-> ($past(frm_q) == $past(cnt_max_i) && st_q == S_IDLE));

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q;
  logic [NUM_CS-1:0] sel_q, sel_new, wv_cs;
  logic [DIV_W-1:0]  div_q, div_new, wv;
  reg_addr_e         addr;

  logic        start, stop, busy;
  logic        tx_push, tx_pop, tx_full, tx_empty;
  logic        rx_push, rx_pop, rx_full, rx_empty;
  logic [15:0] tx_rdata, rx_wdata, rx_rdata;
  logic [LW-1:0] tx_lvl, rx_lvl;

  assign addr  = reg_addr_e'(reg_addr_i);
  assign start = reg_we_i && addr == A_ENABLE && reg_wdata_i[0] && !en_q;
  assign stop  = reg_we_i && addr == A_ENABLE && !reg_wdata_i[0];

  // divisor: round up to even, floor 2, clamp at top
  assign wv = reg_wdata_i[DIV_W-1:0];
  always_comb begin
    if (wv < DIV_W'(2))  div_new = DIV_W'(2);
    else if (wv[0])      div_new = (&wv) ? wv - DIV_W'(1) : wv + DIV_W'(1);
    else                 div_new = wv;
  end

  // keep lowest set bit only
  assign wv_cs   = reg_wdata_i[NUM_CS-1:0];
  assign sel_new = wv_cs & (~wv_cs + NUM_CS'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      sel_q  <= '0;
      div_q  <= DIV_W'(2);
    end else if (reg_we_i) begin
      unique case (addr)
        A_CTRL:   if (!en_q) ctrl_q <= ctrl_t'(reg_wdata_i[3:0]);
        A_COUNT:  if (!en_q) cnt_q  <= reg_wdata_i[CNT_W-1:0];
        A_DIV:    if (!en_q) div_q  <= div_new;
        A_ENABLE: en_q  <= reg_wdata_i[0];
        A_SELECT: sel_q <= sel_new;
        default: ;
      endcase
    end
  end

  assign tx_push = reg_we_i && addr == A_DATA && !tx_full;
  assign rx_pop  = reg_re_i && addr == A_DATA;

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      A_CTRL:   reg_rdata_o = 32'(ctrl_q);
      A_COUNT:  reg_rdata_o = 32'(cnt_q);
      A_ENABLE: reg_rdata_o = 32'(en_q);
      A_SELECT: reg_rdata_o = 32'(sel_q);
      A_DIV:    reg_rdata_o = 32'(div_q);
      A_RXLVL:  reg_rdata_o = 32'(rx_lvl);
      A_TXLVL:  reg_rdata_o = 32'(tx_lvl);
      A_STATUS: reg_rdata_o = {29'h0, rx_empty, tx_full, busy};
      A_DATA:   reg_rdata_o = 32'(rx_rdata);
      default:  reg_rdata_o = '0;
    endcase
  end

  spim_fifo #(.DW(FRAME_W), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni, .clr_i(stop),
    .push_i(tx_push), .wdata_i(reg_wdata_i[15:0]),
    .pop_i(tx_pop), .rdata_o(tx_rdata),
    .full_o(tx_full), .empty_o(tx_empty), .level_o(tx_lvl)
  );

  spim_fifo #(.DW(FRAME_W), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni, .clr_i(stop),
    .push_i(rx_push), .wdata_i(rx_wdata),
    .pop_i(rx_pop), .rdata_o(rx_rdata),
    .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_lvl)
  );

  spim_engine #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .stop_i(stop),
    .cpol_i(ctrl_q.cpol), .cpha_i(ctrl_q.cpha),
    .wide_i(ctrl_q.wide), .rx_only_i(ctrl_q.rx_only),
    .half_i(div_q[DIV_W-1:1]), .cnt_max_i(cnt_q),
    .tx_empty_i(tx_empty), .tx_data_i(tx_rdata), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_wdata),
    .miso_i, .sclk_o, .mosi_o, .busy_o(busy)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = ~sel_q[g];
  end

  assert_div_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q[0] == 1'b0) && (div_q != '0));

  assert_cs_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (tx_lvl == '0 && rx_lvl == '0 && !busy));

  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> ($stable(ctrl_q) && $stable(cnt_q) && $stable(div_q)));

endmodule

// File: tb/sim_spi_master_ctl.sv
`timescale 1ns/1ps
module sim_spi_master_ctl;

  localparam int NCS = 4;
  localparam int AD_CTRL = 0, AD_COUNT = 1, AD_EN = 2, AD_SEL = 3, AD_DIV = 4;
  localparam int AD_RXL = 5, AD_TXL = 6, AD_ST = 7, AD_DATA = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso, inv = 1'b0;
  logic [NCS-1:0] cs_n;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign miso = inv ? ~mosi : mosi;

  spi_master_ctl #(.NUM_CS(NCS), .DEPTH(4), .CNT_W(6), .DIV_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  // cycle monitor: edge count, min gap between edges, mosi watch
  int cyc = 0, edges = 0, last_tog = -1, min_gap = 1000000, mosi_bad = 0;
  int gap_req = 0, gap_seen = 0;
  bit mosi_watch = 1'b0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (gap_req != gap_seen) begin
      gap_seen = gap_req; min_gap = 1000000; last_tog = -1;
    end
    if (sclk !== sclk_prev) begin
      edges++;
      if (last_tog >= 0 && cyc - last_tog < min_gap) min_gap = cyc - last_tog;
      last_tog = cyc;
    end
    sclk_prev = sclk;
    if (mosi_watch && mosi !== 1'b0) mosi_bad++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = 4'(a);
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int g = 0;
    do begin rd(AD_ST, s); g++; end while (s[0] && g < 20000);
  endtask

  function automatic logic [15:0] pat(input int i, input bit wide);
    logic [15:0] d;
    d = 16'((i + 1) * 16'h1357) ^ 16'hA5C3;
    return wide ? d : {8'h00, d[7:0]};
  endfunction

  // full-duplex loopback transfer of nfr frames
  task automatic run_fd(input logic [3:0] ctrl, input int div, input int half, input int nfr, input bit iv);
    logic [31:0] v;
    int e0, bits;
    bit wide = ctrl[2];
    bits = wide ? 16 : 8;
    inv = iv;
    wr(AD_CTRL, 32'(ctrl)); wr(AD_DIV, 32'(div)); wr(AD_COUNT, 32'(nfr - 1));
    e0 = edges; gap_req++;
    wr(AD_EN, 1);
    for (int i = 0; i < nfr; i++) wr(AD_DATA, 32'(pat(i, wide)));
    wait_idle();
    chk("R3 edge count", 32'(edges - e0), 32'(2 * bits * nfr));
    chk("R2 half period", 32'(min_gap), 32'(half));
    chk("R3 idle level", 32'(sclk), 32'(ctrl[0]));
    for (int i = 0; i < nfr; i++) begin
      logic [15:0] ex;
      ex = iv ? ~pat(i, wide) : pat(i, wide);
      if (!wide) ex = {8'h00, ex[7:0]};
      rd(AD_DATA, v);
      chk("R3 rx data", v, 32'(ex));
    end
    rd(AD_ST, v); chk("R4 done status", v, 32'h4);
    e0 = edges;
    wr(AD_DATA, 32'h0055);
    repeat (60) @(negedge clk);
    chk("R5 no extra frame", 32'(edges - e0), 0);
    rd(AD_TXL, v); chk("R5 tx held", v, 1);
    wr(AD_EN, 0);
    rd(AD_TXL, v); chk("R9 tx flushed", v, 0);
    chk("R9 idle level", 32'(sclk), 32'(ctrl[0]));
    inv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s;
    int e0, n, bad, g;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(AD_ST, v);  chk("R1 status", v, 32'h4);
    chk("R1 cs", 32'(cs_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);
    rd(AD_DIV, v); chk("R1 divisor", v, 2);
    rd(AD_RXL, v); chk("R1 rx level", v, 0);
    rd(AD_TXL, v); chk("R1 tx level", v, 0);

    // R2 divisor rounding
    wr(AD_DIV, 3);        rd(AD_DIV, v); chk("R2 odd", v, 4);
    wr(AD_DIV, 0);        rd(AD_DIV, v); chk("R2 zero", v, 2);
    wr(AD_DIV, 1);        rd(AD_DIV, v); chk("R2 one", v, 2);
    wr(AD_DIV, 32'hFFFF); rd(AD_DIV, v); chk("R2 top", v, 32'hFFFE);
    wr(AD_DIV, 10);       rd(AD_DIV, v); chk("R2 even", v, 10);

    // R3 all modes, both widths
    run_fd(4'b0000, 4, 2, 3, 1'b0);
    run_fd(4'b0111, 6, 3, 2, 1'b1);
    run_fd(4'b0010, 2, 1, 4, 1'b0);
    run_fd(4'b0101, 3, 2, 1, 1'b0);

    // R6 transmit underrun hold
    wr(AD_CTRL, 0); wr(AD_DIV, 2); wr(AD_COUNT, 1);
    e0 = edges;
    wr(AD_EN, 1); wr(AD_DATA, 32'h81);
    repeat (80) @(negedge clk);
    chk("R6 one frame", 32'(edges - e0), 16);
    rd(AD_ST, v); chk("R6 busy held", 32'(v[0]), 1);
    chk("R6 clock idle", 32'(sclk), 0);
    wr(AD_DATA, 32'h7E);
    wait_idle();
    chk("R6 resumed", 32'(edges - e0), 32);
    rd(AD_DATA, v); chk("R6 data0", v, 32'h81);
    rd(AD_DATA, v); chk("R6 data1", v, 32'h7E);
    wr(AD_EN, 0);

    // R7 R8 receive-only with overrun hold
    inv = 1'b1;
    wr(AD_CTRL, 32'h8); wr(AD_DIV, 2); wr(AD_COUNT, 9);
    e0 = edges; mosi_watch = 1'b1;
    wr(AD_EN, 1);
    repeat (300) @(negedge clk);
    rd(AD_RXL, v); chk("R7 rx full level", v, 4);
    chk("R7 held edges", 32'(edges - e0), 64);
    rd(AD_ST, v); chk("R7 busy held", 32'(v[0]), 1);
    n = 0; bad = 0; g = 0;
    while (n < 10 && g < 5000) begin
      rd(AD_ST, s);
      if (!s[2]) begin rd(AD_DATA, v); if (v !== 32'hFF) bad++; n++; end
      g++;
    end
    wait_idle();
    chk("R7 frames read", 32'(n), 10);
    chk("R7 rx values", 32'(bad), 0);
    chk("R8 edges", 32'(edges - e0), 160);
    mosi_watch = 1'b0;
    chk("R8 mosi low", 32'(mosi_bad), 0);
    wr(AD_EN, 0);

    // R4 all-ones frame count, 16-bit receive-only
    wr(AD_CTRL, 32'hC); wr(AD_COUNT, 63);
    e0 = edges;
    wr(AD_EN, 1);
    n = 0; bad = 0; g = 0;
    while (n < 64 && g < 20000) begin
      rd(AD_ST, s);
      if (!s[2]) begin rd(AD_DATA, v); if (v !== 32'hFFFF) bad++; n++; end
      g++;
    end
    wait_idle();
    chk("R4 full count frames", 32'(n), 64);
    chk("R4 full count data", 32'(bad), 0);
    chk("R4 full count edges", 32'(edges - e0), 2048);
    rd(AD_RXL, v); chk("R4 no extra", v, 0);
    wr(AD_EN, 0);
    inv = 1'b0;

    // R10 config locked while enabled
    wr(AD_CTRL, 0); wr(AD_COUNT, 3); wr(AD_DIV, 4);
    wr(AD_EN, 1);
    wr(AD_CTRL, 32'hF); wr(AD_COUNT, 7); wr(AD_DIV, 10);
    rd(AD_CTRL, v);  chk("R10 ctrl", v, 0);
    rd(AD_COUNT, v); chk("R10 count", v, 3);
    rd(AD_DIV, v);   chk("R10 div", v, 4);
    wr(AD_EN, 0);

    // R9 disable mid-frame
    wr(AD_DIV, 8); wr(AD_COUNT, 3);
    wr(AD_EN, 1);
    wr(AD_DATA, 1); wr(AD_DATA, 2); wr(AD_DATA, 3);
    repeat (10) @(negedge clk);
    wr(AD_EN, 0);
    rd(AD_ST, v);  chk("R9 status", v, 32'h4);
    rd(AD_TXL, v); chk("R9 tx level", v, 0);
    chk("R9 sclk", 32'(sclk), 0);
    e0 = edges;
    repeat (50) @(negedge clk);
    chk("R9 stopped", 32'(edges - e0), 0);

    // R11 select
    wr(AD_SEL, 32'b0110); chk("R11 lowest bit", 32'(cs_n), 32'b1101);
    wr(AD_SEL, 32'b1000); chk("R11 single", 32'(cs_n), 32'b0111);
    wr(AD_SEL, 0);        chk("R11 none", 32'(cs_n), 32'hF);

    // R12 queue capacity
    for (int i = 0; i < 6; i++) wr(AD_DATA, 32'(16'h10 + i));
    rd(AD_TXL, v); chk("R12 tx level", v, 4);
    rd(AD_ST, v);  chk("R12 full flag", v, 32'h6);
    wr(AD_DIV, 2); wr(AD_COUNT, 3);
    wr(AD_EN, 1);
    wait_idle();
    rd(AD_RXL, v); chk("R12 rx level", v, 4);
    for (int i = 0; i < 4; i++) begin
      rd(AD_DATA, v); chk("R12 kept data", v, 32'(16'h10 + i));
    end
    wr(AD_EN, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule